// File: doc/BRIEF.md
# I/O Read Merge Register

This block sits between the replay of retired I/O space loads and the off-chip read path. Loads arrive in program order, at most one per clock. The block combines loads that arrive one after another into one wider read. It keeps a single open window, which holds the size class of the loads it contains, an aligned block base and a per-unit mask of the units gathered so far.

Each load that arrives either joins the open window or closes it. When it closes the window, that load starts a fresh window in the same cycle. A window also closes on a barrier or after a long stretch with no new loads. Each closed window becomes one read request (base, size, mask) in an in-order queue toward the bus.

Size codes used on `in_size` and `out_size`: 0 = byte, 1 = word, 2 = longword (4 bytes), 3 = quadword (8 bytes). Load addresses are taken as naturally aligned to their size.

Top module: `io_rd_merge`

## Requirements
- R1: A byte (code 0) or word (code 1) load never merges. It closes any open window and opens its own window with base equal to its full address, its size code and mask 0x01.
- R2: A longword (code 2) load merges into an open longword window when its 32-byte aligned block equals the window base and its unit index addr[4:2] is strictly above the highest index already merged. Mask bit [index] is then set.
- R3: A quadword (code 3) load merges under the same ascending rule within a 64-byte aligned block, with unit index addr[5:3].
- R4: With `cfg_quad32` = 1, quadword windows use 32-byte aligned blocks with unit index addr[4:3] (mask bits 3:0 only). The bit is sampled with each load.
- R5: A load that cannot merge (different size, different block, or index at or below the highest merged) emits the open window and opens a window holding only itself, in the same cycle.
- R6: A barrier taken while a window is open emits it. A load that arrives in the same cycle as a barrier always starts a new window.
- R7: After IDLE_CYCLES consecutive cycles with no accepted load, an open window is emitted. The request is visible after the edge that ends the IDLE_CYCLES-th idle cycle.
- R8: Requests leave in the order they were formed. The head request holds steady while `out_ready` is low.
- R9: While the queue is full, `in_ready` is low. Loads, barriers and the idle timer are then not acted on, and the open window is kept unchanged.
- R10: After reset no window is open, the queue is empty, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A replayed load is present |
| in_ready | output | 1 | Block can take a load or barrier this cycle |
| in_addr | input | AW | Physical address of the load |
| in_size | input | 2 | Size code of the load |
| in_barrier | input | 1 | Barrier issued this cycle |
| cfg_quad32 | input | 1 | Limit quadword merging to 32-byte blocks |
| out_valid | output | 1 | Head request present |
| out_ready | input | 1 | Consumer takes head request |
| out_base | output | AW | Base address of the request |
| out_size | output | 2 | Size code of the request |
| out_mask | output | 8 | Units contained in the request |

## Verification
The assertions check on every cycle that small loads never join a window and always get mask 0x01. They also check that a merge adds exactly one mask bit, that barriers and idle expiry emit a window only at their proper moments, that a full queue freezes the window and that a stalled head stays put. The actual merge decisions can only be shown by the bench's scenarios. These include block boundaries, repeated and descending indices, the 32-byte quadword mode, the exact idle expiry cycle, and the order of requests drained after back-pressure.

// File: rtl/io_rd_merge_pkg.sv
package io_rd_merge_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_QUAD = 2'd3
  } ld_size_e;

  localparam int UNITS = 8;
  localparam int IDX_W = 3;
endpackage

// File: rtl/io_rd_merge_rules.sv
module io_rd_merge_rules
  import io_rd_merge_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]    ld_addr,
  input  logic [1:0]       ld_size,
  input  logic             quad32,
  input  logic             force_new,
  input  logic             win_open,
  input  logic [1:0]       win_size,
  input  logic [AW-1:0]    win_base,
  input  logic [IDX_W-1:0] win_last,
  output logic             can_merge,
  output logic [AW-1:0]    blk_base,
  output logic [IDX_W-1:0] unit_idx
);
  localparam logic [AW-1:0] BLK32 = ~AW'(31);
  localparam logic [AW-1:0] BLK64 = ~AW'(63);

  logic wide_size;

  always_comb begin
    blk_base = ld_addr;
    unit_idx = '0;
    unique case (ld_size)
      SZ_LONG: begin
        blk_base = ld_addr & BLK32;
        unit_idx = ld_addr[4:2];
      end
      SZ_QUAD: begin
        if (quad32) begin
          blk_base = ld_addr & BLK32;
          unit_idx = {1'b0, ld_addr[4:3]};
        end else begin
          blk_base = ld_addr & BLK64;
          unit_idx = ld_addr[5:3];
        end
      end
      default: begin
        blk_base = ld_addr;
        unit_idx = '0;
      end
    endcase
  end

  assign wide_size = (ld_size == SZ_LONG) || (ld_size == SZ_QUAD);

  assign can_merge = win_open && !force_new && wide_size &&
                     (ld_size == win_size) && (blk_base == win_base) &&
                     (unit_idx > win_last);
endmodule

// File: rtl/io_rd_merge_idle.sv
module io_rd_merge_idle #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_open,
  input  logic activity,
  output logic at_limit
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign at_limit = (cnt_q == LAST);

  always_comb begin
    cnt_en = 1'b1;
    if (!win_open || activity) begin
      cnt_d = '0;
    end else if (!at_limit) begin
      cnt_d = cnt_q + CW'(1);
    end else begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/io_rd_merge_fifo.sv
module io_rd_merge_fifo #(
  parameter int W     = 42,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         full,
  output logic         nonempty,
  output logic [W-1:0] dout
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full     = (cnt_q == CW'(DEPTH));
  assign nonempty = (cnt_q != '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && nonempty;
  assign dout     = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
    if (do_pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
    if (do_push && !do_pop) cnt_d = cnt_q + CW'(1);
    if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (do_push || do_pop) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wr_q == PW'(e))) begin
        mem[e] <= din;
      end
    end
  end
endmodule

// File: rtl/io_rd_merge.sv
module io_rd_merge
  import io_rd_merge_pkg::*;
#(
  parameter int AW          = 32,
  parameter int IDLE_CYCLES = 1024,
  parameter int Q_DEPTH     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [1:0]    in_size,
  input  logic          in_barrier,
  input  logic          cfg_quad32,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_base,
  output logic [1:0]    out_size,
  output logic [UNITS-1:0] out_mask
);
  localparam int REQ_W = AW + 2 + UNITS;

  logic             win_open_q, win_open_d;
  logic [1:0]       win_size_q, win_size_d;
  logic [AW-1:0]    win_base_q, win_base_d;
  logic [IDX_W-1:0] win_last_q, win_last_d;
  logic [UNITS-1:0] win_mask_q, win_mask_d;
  logic             win_en;

  logic             q_full, accept, bar_take, idle_lim, idle_fire, push;
  logic             can_merge;
  logic [AW-1:0]    blk_base;
  logic [IDX_W-1:0] unit_idx;
  logic [REQ_W-1:0] q_dout;

  assign in_ready  = !q_full;
  assign accept    = in_valid && in_ready;
  assign bar_take  = in_barrier && in_ready;
  assign idle_fire = idle_lim && in_ready && !accept;

  io_rd_merge_rules #(.AW(AW)) rules_i (
    .ld_addr   (in_addr),
    .ld_size   (in_size),
    .quad32    (cfg_quad32),
    .force_new (bar_take),
    .win_open  (win_open_q),
    .win_size  (win_size_q),
    .win_base  (win_base_q),
    .win_last  (win_last_q),
    .can_merge (can_merge),
    .blk_base  (blk_base),
    .unit_idx  (unit_idx)
  );

  io_rd_merge_idle #(.LIMIT(IDLE_CYCLES)) idle_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_open (win_open_q),
    .activity (accept),
    .at_limit (idle_lim)
  );

  always_comb begin
    win_open_d = win_open_q;
    win_size_d = win_size_q;
    win_base_d = win_base_q;
    win_last_d = win_last_q;
    win_mask_d = win_mask_q;
    push       = 1'b0;
    if (accept) begin
      if (can_merge) begin
        win_mask_d = win_mask_q | (UNITS'(1) << unit_idx);
        win_last_d = unit_idx;
      end else begin
        push       = win_open_q;
        win_open_d = 1'b1;
        win_size_d = in_size;
        win_base_d = blk_base;
        win_last_d = unit_idx;
        win_mask_d = UNITS'(1) << unit_idx;
      end
    end else if (win_open_q && (bar_take || idle_fire)) begin
      push       = 1'b1;
      win_open_d = 1'b0;
    end
  end

  assign win_en = accept || push;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_open_q <= 1'b0;
      win_size_q <= SZ_BYTE;
      win_base_q <= '0;
      win_last_q <= '0;
      win_mask_q <= '0;
    end else if (win_en) begin
      win_open_q <= win_open_d;
      win_size_q <= win_size_d;
      win_base_q <= win_base_d;
      win_last_q <= win_last_d;
      win_mask_q <= win_mask_d;
    end
  end

  io_rd_merge_fifo #(.W(REQ_W), .DEPTH(Q_DEPTH)) q_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .din      ({win_base_q, win_size_q, win_mask_q}),
    .pop      (out_ready),
    .full     (q_full),
    .nonempty (out_valid),
    .dout     (q_dout)
  );

  assign out_base = q_dout[REQ_W-1 -: AW];
  assign out_size = q_dout[UNITS +: 2];
  assign out_mask = q_dout[UNITS-1:0];
endmodule

// File: rtl/io_rd_merge_chk.sv
module io_rd_merge_chk #(
  parameter int AW          = 32,
  parameter int IDLE_CYCLES = 1024
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    in_size,
  input logic          in_barrier,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_base,
  input logic [1:0]    out_size,
  input logic [7:0]    out_mask,
  input logic          win_open,
  input logic [AW-1:0] win_base,
  input logic [7:0]    win_mask,
  input logic          push
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);

  logic          acc, bar;
  logic [CW-1:0] quiet_q;

  assign acc = in_valid && in_ready;
  assign bar = in_barrier && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= '0;
    end else if (acc || !win_open) begin
      quiet_q <= '0;
    end else if (quiet_q != CW'(IDLE_CYCLES)) begin
      quiet_q <= quiet_q + CW'(1);
    end
  end

  // R1: a small load never joins an open window
  a_r1_small_closes: assert property (@(posedge clk) disable iff (!rst_n)
    acc && win_open && (in_size < 2'd2) |-> push);

  // R1: small requests carry a single-unit mask
  a_r1_small_mask: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_size < 2'd2) |-> out_mask == 8'h01);

  // R2: a merge adds exactly one unit
  a_r2_merge_one_unit: assert property (@(posedge clk) disable iff (!rst_n)
    acc && win_open && !push |=>
      $countones(win_mask) == $countones($past(win_mask)) + 1);

  // R6: barrier on an open window emits it
  a_r6_barrier_close: assert property (@(posedge clk) disable iff (!rst_n)
    bar && win_open |-> push);

  // R7: a spontaneous close only after the full quiet period
  a_r7_no_early_close: assert property (@(posedge clk) disable iff (!rst_n)
    push && !acc && !bar |-> quiet_q >= CW'(IDLE_CYCLES - 1));

  // R7: expiry is not missed
  a_r7_idle_close: assert property (@(posedge clk) disable iff (!rst_n)
    win_open && in_ready && !acc && (quiet_q >= CW'(IDLE_CYCLES - 1)) |-> push);

  // R8: stalled head stays put
  a_r8_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_base) &&
      $stable(out_size) && $stable(out_mask));

  // R9: full queue freezes the window
  a_r9_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(win_open) && $stable(win_base) && $stable(win_mask));

  // R9: nothing is emitted into a full queue
  a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !push);
endmodule

bind io_rd_merge io_rd_merge_chk #(.AW(AW), .IDLE_CYCLES(IDLE_CYCLES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_size    (in_size),
  .in_barrier (in_barrier),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_base   (out_base),
  .out_size   (out_size),
  .out_mask   (out_mask),
  .win_open   (win_open_q),
  .win_base   (win_base_q),
  .win_mask   (win_mask_q),
  .push       (push)
);

// File: tb/io_rd_merge_tb_top.sv
module io_rd_merge_tb_top;
  localparam int AW = 32;
  localparam int IDLE = 1024;
  localparam int QD = 4;
  localparam int VW = 1 + 2 + 32 + 1 + 1 + 1 + 2 + 32 + 8 + 4;
  localparam int NV = 21;

  // fields: valid, size, addr, barrier, quad32 | exp_valid, exp_size, exp_base, exp_mask | req
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1,2'd2,32'h100,1'b0,1'b0, 1'b0,2'd0,32'h0,  8'h00, 4'd2},  // R2 open
    {1'b1,2'd2,32'h108,1'b0,1'b0, 1'b0,2'd0,32'h0,  8'h00, 4'd2},  // R2 skip merge
    {1'b1,2'd2,32'h11C,1'b0,1'b0, 1'b0,2'd0,32'h0,  8'h00, 4'd2},  // R2 top unit
    {1'b1,2'd2,32'h120,1'b0,1'b0, 1'b1,2'd2,32'h100,8'h85, 4'd5},  // R5 new block
    {1'b1,2'd2,32'h124,1'b0,1'b0, 1'b0,2'd0,32'h0,  8'h00, 4'd2},  // R2
    {1'b1,2'd2,32'h124,1'b0,1'b0, 1'b1,2'd2,32'h120,8'h03, 4'd5},  // R5 equal index
    {1'b1,2'd3,32'h128,1'b0,1'b0, 1'b1,2'd2,32'h120,8'h02, 4'd5},  // R5 size change
    {1'b1,2'd3,32'h138,1'b0,1'b0, 1'b0,2'd0,32'h0,  8'h00, 4'd3},  // R3 merge
    {1'b1,2'd3,32'h130,1'b0,1'b0, 1'b1,2'd3,32'h100,8'hA0, 4'd5},  // R5 descending
    {1'b0,2'd0,32'h0,  1'b1,1'b0, 1'b1,2'd3,32'h100,8'h40, 4'd6},  // R6 barrier
    {1'b1,2'd0,32'h203,1'b0,1'b0, 1'b0,2'd0,32'h0,  8'h00, 4'd1},  // R1 byte open
    {1'b1,2'd0,32'h204,1'b0,1'b0, 1'b1,2'd0,32'h203,8'h01, 4'd1},  // R1 byte no merge
    {1'b1,2'd1,32'h206,1'b0,1'b0, 1'b1,2'd0,32'h204,8'h01, 4'd1},  // R1
    {1'b1,2'd2,32'h300,1'b1,1'b0, 1'b1,2'd1,32'h206,8'h01, 4'd1},  // R1 word emitted
    {1'b1,2'd2,32'h304,1'b1,1'b0, 1'b1,2'd2,32'h300,8'h01, 4'd6},  // R6 load+barrier
    {1'b1,2'd3,32'h340,1'b0,1'b1, 1'b1,2'd2,32'h300,8'h02, 4'd4},  // R4 open 32B quad
    {1'b1,2'd3,32'h358,1'b0,1'b1, 1'b0,2'd0,32'h0,  8'h00, 4'd4},  // R4 merge idx3
    {1'b1,2'd3,32'h360,1'b0,1'b1, 1'b1,2'd3,32'h340,8'h09, 4'd4},  // R4 32B boundary
    {1'b1,2'd3,32'h368,1'b0,1'b0, 1'b1,2'd3,32'h360,8'h01, 4'd3},  // R3 other 64B block
    {1'b0,2'd0,32'h0,  1'b1,1'b0, 1'b1,2'd3,32'h340,8'h20, 4'd3},  // R3 idx5 of 64B
    {1'b0,2'd0,32'h0,  1'b0,1'b0, 1'b0,2'd0,32'h0,  8'h00, 4'd8}   // R8 queue drained
  };

  logic          clk, rst_n;
  logic          in_valid, in_ready, in_barrier, cfg_quad32;
  logic [AW-1:0] in_addr;
  logic [1:0]    in_size;
  logic          out_valid, out_ready;
  logic [AW-1:0] out_base;
  logic [1:0]    out_size;
  logic [7:0]    out_mask;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  io_rd_merge #(.AW(AW), .IDLE_CYCLES(IDLE), .Q_DEPTH(QD)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_size(in_size), .in_barrier(in_barrier),
    .cfg_quad32(cfg_quad32), .out_valid(out_valid), .out_ready(out_ready),
    .out_base(out_base), .out_size(out_size), .out_mask(out_mask)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic check_out(input string rq, input bit ev, input logic [1:0] esz,
                           input logic [AW-1:0] eb, input logic [7:0] em);
    if (!ev) begin
      check(out_valid == 1'b0, rq, "out_valid", 64'(out_valid), 64'd0);
    end else begin
      check(out_valid === 1'b1 && out_size === esz && out_base === eb && out_mask === em,
            rq, "request {valid,size,base,mask}",
            {out_valid, 5'd0, out_size, out_base, 16'd0, out_mask},
            {1'b1, 5'd0, esz, eb, 16'd0, em});
    end
  endtask

  task automatic step(input bit v, input logic [1:0] sz, input logic [AW-1:0] a,
                      input bit b, input bit q);
    in_valid = v; in_size = sz; in_addr = a; in_barrier = b; cfg_quad32 = q;
    @(posedge clk); #1;
    in_valid = 1'b0; in_barrier = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_barrier = 1'b0; cfg_quad32 = 1'b0;
    in_addr = '0; in_size = 2'd0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R10 reset state
    check(out_valid == 1'b0, "R10", "out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R10", "in_ready after reset", 64'(in_ready), 64'd1);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] w;
      w = VEC[i];
      step(w[VW-1], w[VW-2 -: 2], w[VW-4 -: 32], w[VW-36], w[VW-37]);
      check_out($sformatf("R%0d step %0d", w[3:0], i), w[VW-38], w[VW-39 -: 2],
                w[VW-41 -: 32], w[11:4]);
    end

    // R7 idle expiry
    step(1'b1, 2'd2, 32'h400, 1'b0, 1'b0);
    repeat (IDLE - 1) @(posedge clk);
    #1;
    check_out("R7 before expiry", 1'b0, 2'd0, '0, 8'h00);
    @(posedge clk); #1;
    check_out("R7 at expiry", 1'b1, 2'd2, 32'h400, 8'h01);
    @(posedge clk); #1;

    // R9 back-pressure and R8 ordering
    out_ready = 1'b0;
    for (int k = 0; k < 5; k++) step(1'b1, 2'd0, 32'h500 + k, 1'b0, 1'b0);
    check(in_ready == 1'b0, "R9", "in_ready with full queue", 64'(in_ready), 64'd0);
    in_valid = 1'b1; in_size = 2'd2; in_addr = 32'h600; in_barrier = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    in_valid = 1'b0; in_barrier = 1'b0;
    check(in_ready == 1'b0, "R9", "in_ready still low", 64'(in_ready), 64'd0);
    check_out("R8 head held", 1'b1, 2'd0, 32'h500, 8'h01);
    out_ready = 1'b1;
    for (int k = 1; k < 4; k++) begin
      @(posedge clk); #1;
      check_out("R8 drain order", 1'b1, 2'd0, 32'h500 + k, 8'h01);
    end
    @(posedge clk); #1;
    check_out("R8 queue empty", 1'b0, 2'd0, '0, 8'h00);
    step(1'b0, 2'd0, '0, 1'b1, 1'b0);
    check_out("R9 window kept while full", 1'b1, 2'd0, 32'h504, 8'h01);

    // R10 reset discards an open window
    @(posedge clk); #1;
    step(1'b1, 2'd2, 32'h700, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    step(1'b0, 2'd0, '0, 1'b1, 1'b0);
    check_out("R10 no window after reset", 1'b0, 2'd0, '0, 8'h00);

    finish_run();
  end
endmodule